// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter with a 3½-digit decimal readout. It runs the analog front end through a repeating cycle of three phases: zeroing, where the inputs are tied to the common node; a fixed-length signal integration; and a variable-length reference de-integration. Each phase is selected through a one-hot set of switch enables. The block samples a single comparator bit that reports whether the integrator output is above zero.

At the end of integration the comparator bit is taken as the input polarity. That polarity picks which way the reference is connected, so that the integrator is pulled back toward zero. During de-integration a BCD counter advances every clock until the comparator reports that the integrator has crossed zero. The count, together with the polarity, then goes into output registers that a display driver reads. Those registers hold steady while the next conversion runs. A one-clock strobe marks each new result.

With the default integration length of 1000 clocks, the reading equals 1000 × |Vin| / Vref. A conversion that never crosses zero within the counter's range ends at full scale and raises an overrange flag.

Top module: `dslope_seq`

## Requirements
- R1: Phases follow the fixed order zeroing, integration, de-integration, and then back to zeroing. Between any two phases there is exactly one clock with every switch enable low.
- R2: At most one of the four switch enables is high in any clock. `sw_zero` is high only while zeroing and `sw_sig` only while integrating. During de-integration exactly one of `sw_ref_pos` or `sw_ref_neg` is high.
- R3: Zeroing lasts AZ_CYCLES clocks (default 1000) and integration lasts INT_CYCLES clocks (default 1000). After a reset, zeroing is counted from the first clock following the last reset edge.
- R4: The value of `cmp_hi` in the last integration clock is stored as the polarity. A 1 means positive and selects `sw_ref_pos` for the whole of the de-integration that follows. A 0 means negative and selects `sw_ref_neg`.
- R5: The reading is the number of de-integration clocks before the first clock in which `cmp_hi` differs from the stored polarity. That crossing clock is the last clock of de-integration, so the reference stays applied for the reading plus one clock.
- R6: `rd_bcd` holds four BCD digits, with thousands in [15:12], hundreds in [11:8], tens in [7:4] and units in [3:0]. Each digit is 0 to 9 and the value never exceeds 1999.
- R7: If the count has reached 1999 and the clock shows no crossing, de-integration ends after that clock (2000 clocks of reference in total). The result is then 1999 with `rd_ovr`=1. Every other result has `rd_ovr`=0, including a crossing at exactly 1999.
- R8: `rd_bcd`, `rd_pos` and `rd_ovr` change only on the clock edge that ends de-integration. They hold through the whole of the following conversion.
- R9: `rd_done` is high for exactly one clock: the clock right after de-integration ends, in which the new result is first visible.
- R10: A synchronous active-low reset, sampled on a clock edge, returns the block to the start of zeroing. It also clears `rd_bcd`, `rd_pos`, `rd_ovr` and `rd_done`, even in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_hi | input | 1 | Comparator: 1 when the integrator output is above zero |
| sw_zero | output | 1 | Tie inputs to common (zeroing phase) |
| sw_sig | output | 1 | Connect input signal to integrator |
| sw_ref_pos | output | 1 | Reference connected for a positive input |
| sw_ref_neg | output | 1 | Reference connected for a negative input |
| rd_bcd | output | 16 | Latched reading, four BCD digits |
| rd_pos | output | 1 | Latched polarity, 1 = positive |
| rd_ovr | output | 1 | Latched overrange flag |
| rd_done | output | 1 | One-clock strobe on a new result |

## Verification
The hardest cases to reach from the ports are the edges of de-integration: a crossing in the very last counted clock (reading 1999), a crossing one clock too late (overrange), and a zero input that crosses at once. The comparator is driven by a behavioural integrator in the bench. That model adds the chosen input level for every integration clock and removes one reference step for every de-integration clock, so a requested input value lands the crossing on an exact clock. Directed values at 0, ±1, ±1999 and ±2000 sit on these edges, and seeded random levels fill in between. A reset in the middle of an integration exercises the recovery path.

// File: rtl/dslope_pkg.sv
// Package: shared phase encoding and a constant BCD conversion helper.
// Assumes at most eight BCD digits are ever requested.
package dslope_pkg;

    typedef enum logic [2:0] {
        PH_ZERO   = 3'd0,
        PH_GAP_ZI = 3'd1,
        PH_INTEG  = 3'd2,
        PH_GAP_ID = 3'd3,
        PH_DEINT  = 3'd4,
        PH_GAP_DZ = 3'd5
    } phase_t;

    // Convert a non-negative integer to packed BCD, eight digits wide.
    function automatic logic [31:0] bcd_of(input int unsigned value);
        logic [31:0] r;
        int unsigned v;
        r = '0;
        v = value;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/dslope_interval_timer.sv
// Module: binary interval timer used for the two fixed-length phases.
// Counts up each clock unless cleared; flags the clock whose count equals
// the supplied limit. Assumes limit fits in W bits.
module dslope_interval_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         last
);

    logic [W-1:0] cnt_q;

    // Advance the interval count, or restart it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal clock of the current interval.
    always_comb begin
        last = (cnt_q == limit);
    end

endmodule

// File: rtl/dslope_bcd_counter.sv
// Module: ripple-carry decimal counter of DIGITS digits.
// Each digit rolls 9 -> 0 and carries into the next. The whole counter
// wraps to zero when incremented at MAX_BCD. at_max flags that value.
module dslope_bcd_counter #(
    parameter int              DIGITS  = 4,
    parameter logic [4*DIGITS-1:0] MAX_BCD = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                inc,
    output logic [4*DIGITS-1:0] count,
    output logic                at_max
);

    logic [DIGITS:0]       carry;
    logic [4*DIGITS-1:0]   cnt_q;
    logic [4*DIGITS-1:0]   cnt_d;

    assign carry[0] = inc;

    // One decimal digit per generate slice, carry rippling upward.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = cnt_q[4*g +: 4];

        // Next value of this digit and its carry out.
        always_comb begin
            if (carry[g]) begin
                if (dig == 4'd9) begin
                    cnt_d[4*g +: 4] = 4'd0;
                    carry[g+1]      = 1'b1;
                end else begin
                    cnt_d[4*g +: 4] = dig + 4'd1;
                    carry[g+1]      = 1'b0;
                end
            end else begin
                cnt_d[4*g +: 4] = dig;
                carry[g+1]      = 1'b0;
            end
        end
    end

    // Full-scale flag.
    always_comb begin
        at_max = (cnt_q == MAX_BCD);
    end

    // Count register: clear, wrap at full scale, or take the rippled value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && at_max) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/dslope_phase_fsm.sv
// Module: phase sequencer. Walks zeroing -> integrate -> de-integrate with
// a one-clock break between each, stores the polarity from the comparator
// in the last integration clock, and decides when de-integration ends
// (comparator crossing or counter at full scale).
module dslope_phase_fsm
    import dslope_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmp_hi,
    input  logic   tmr_last,
    input  logic   cnt_at_max,
    output phase_t phase,
    output logic   pol,
    output logic   tmr_clr,
    output logic   cnt_clr,
    output logic   cnt_inc,
    output logic   fin,
    output logic   ovr_hit
);

    phase_t phase_q;
    phase_t phase_d;
    logic   pol_q;
    logic   crossed;

    assign crossed = (cmp_hi != pol_q);

    // Next phase and per-clock control strobes.
    always_comb begin
        phase_d = phase_q;
        tmr_clr = 1'b1;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        fin     = 1'b0;
        ovr_hit = 1'b0;
        unique case (phase_q)
            PH_ZERO: begin
                tmr_clr = tmr_last;
                if (tmr_last) phase_d = PH_GAP_ZI;
            end
            PH_GAP_ZI: begin
                cnt_clr = 1'b1;
                phase_d = PH_INTEG;
            end
            PH_INTEG: begin
                tmr_clr = tmr_last;
                if (tmr_last) phase_d = PH_GAP_ID;
            end
            PH_GAP_ID: begin
                cnt_clr = 1'b1;
                phase_d = PH_DEINT;
            end
            PH_DEINT: begin
                if (crossed) begin
                    fin     = 1'b1;
                    phase_d = PH_GAP_DZ;
                end else if (cnt_at_max) begin
                    fin     = 1'b1;
                    ovr_hit = 1'b1;
                    phase_d = PH_GAP_DZ;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PH_GAP_DZ: begin
                phase_d = PH_ZERO;
            end
            default: begin
                phase_d = PH_ZERO;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ZERO;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Polarity capture at the final integration clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
        end else if (phase_q == PH_INTEG && tmr_last) begin
            pol_q <= cmp_hi;
        end
    end

    assign phase = phase_q;
    assign pol   = pol_q;

endmodule

// File: rtl/dslope_result_latch.sv
// Module: display-side result registers. Loads count, polarity and
// overrange on the finish strobe and raises done for one clock afterwards.
module dslope_result_latch #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] cnt_in,
    input  logic          pol_in,
    input  logic          ovr_in,
    output logic [BW-1:0] rd_bcd,
    output logic          rd_pos,
    output logic          rd_ovr,
    output logic          rd_done
);

    // Hold the reading until the next finish strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bcd <= '0;
            rd_pos <= 1'b0;
            rd_ovr <= 1'b0;
        end else if (load) begin
            rd_bcd <= cnt_in;
            rd_pos <= pol_in;
            rd_ovr <= ovr_in;
        end
    end

    // One-clock new-result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
        end else begin
            rd_done <= load;
        end
    end

endmodule

// File: rtl/dslope_seq.sv
// Module: dual-slope converter sequencer top. Ties the phase sequencer,
// the shared interval timer, the BCD de-integration counter and the
// result registers together, and decodes the one-hot switch enables
// from the phase register so that break clocks have every switch off.
// Assumes cmp_hi is already synchronous to clk.
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int AZ_CYCLES  = 1000,
    parameter int INT_CYCLES = 1000,
    parameter int MAX_COUNT  = 1999,
    parameter int DIGITS     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_hi,
    output logic                sw_zero,
    output logic                sw_sig,
    output logic                sw_ref_pos,
    output logic                sw_ref_neg,
    output logic [4*DIGITS-1:0] rd_bcd,
    output logic                rd_pos,
    output logic                rd_ovr,
    output logic                rd_done
);

    localparam int TMAX = (AZ_CYCLES > INT_CYCLES) ? AZ_CYCLES : INT_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = 4 * DIGITS;
    localparam logic [31:0]   MAX_BCD_ALL = bcd_of(MAX_COUNT);
    localparam logic [BW-1:0] MAX_BCD     = MAX_BCD_ALL[BW-1:0];
    localparam logic [TW-1:0] AZ_LIMIT    = TW'(AZ_CYCLES - 1);
    localparam logic [TW-1:0] INT_LIMIT   = TW'(INT_CYCLES - 1);

    phase_t        phase;
    logic          pol;
    logic          tmr_clr;
    logic          tmr_last;
    logic [TW-1:0] tmr_limit;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          cnt_at_max;
    logic [BW-1:0] cnt_val;
    logic          fin;
    logic          ovr_hit;

    // Interval length for whichever timed phase is active.
    always_comb begin
        tmr_limit = (phase == PH_ZERO) ? AZ_LIMIT : INT_LIMIT;
    end

    dslope_phase_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_hi     (cmp_hi),
        .tmr_last   (tmr_last),
        .cnt_at_max (cnt_at_max),
        .phase      (phase),
        .pol        (pol),
        .tmr_clr    (tmr_clr),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .fin        (fin),
        .ovr_hit    (ovr_hit)
    );

    dslope_interval_timer #(.W(TW)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .last  (tmr_last)
    );

    dslope_bcd_counter #(.DIGITS(DIGITS), .MAX_BCD(MAX_BCD)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .count  (cnt_val),
        .at_max (cnt_at_max)
    );

    dslope_result_latch #(.BW(BW)) lat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fin),
        .cnt_in  (cnt_val),
        .pol_in  (pol),
        .ovr_in  (ovr_hit),
        .rd_bcd  (rd_bcd),
        .rd_pos  (rd_pos),
        .rd_ovr  (rd_ovr),
        .rd_done (rd_done)
    );

    // Switch enables decoded from the registered phase; breaks drive none.
    always_comb begin
        sw_zero    = (phase == PH_ZERO);
        sw_sig     = (phase == PH_INTEG);
        sw_ref_pos = (phase == PH_DEINT) &&  pol;
        sw_ref_neg = (phase == PH_DEINT) && !pol;
    end

endmodule

// File: rtl/dslope_seq_chk.sv
// Module: assertion checker for dslope_seq, attached by bind below.
// Observes only the top-level ports.
module dslope_seq_chk #(
    parameter int AZ_CYCLES  = 1000,
    parameter int INT_CYCLES = 1000,
    parameter int MAX_COUNT  = 1999,
    parameter int DIGITS     = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmp_hi,
    input logic                sw_zero,
    input logic                sw_sig,
    input logic                sw_ref_pos,
    input logic                sw_ref_neg,
    input logic [4*DIGITS-1:0] rd_bcd,
    input logic                rd_pos,
    input logic                rd_ovr,
    input logic                rd_done
);

    localparam int BW = 4 * DIGITS;
    localparam logic [31:0]   MAX_ALL = dslope_pkg::bcd_of(MAX_COUNT);
    localparam logic [BW-1:0] MAX_BCD = MAX_ALL[BW-1:0];

    int   az_run;
    int   sig_run;
    logic rst_seen;

    // Every digit a valid decimal and the value within full scale.
    function automatic logic bcd_ok(input logic [BW-1:0] v);
        logic ok;
        ok = (v <= MAX_BCD);
        for (int i = 0; i < DIGITS; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    // Run lengths of the zeroing and integration enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            az_run  <= 0;
            sig_run <= 0;
        end else begin
            az_run  <= sw_zero ? az_run + 1 : 0;
            sig_run <= sw_sig  ? sig_run + 1 : 0;
        end
    end

    // Remember that the previous edge sampled reset.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R10
    always @(posedge clk) begin
        if (rst_seen) begin
            rst_state_chk: assert (sw_zero && !sw_sig && !sw_ref_pos && !sw_ref_neg
                                   && rd_bcd == '0 && !rd_pos && !rd_ovr && !rd_done);
        end
    end

    // R2
    switch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_zero, sw_sig, sw_ref_pos, sw_ref_neg}));

    // R1
    zero_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_zero) |-> !(sw_sig || sw_ref_pos || sw_ref_neg));

    // R1
    sig_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_sig) |-> $past(sw_zero, 2));

    // R3
    az_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_zero) |-> az_run == AZ_CYCLES);

    // R3
    int_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_sig) |-> sig_run == INT_CYCLES);

    // R4
    ref_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ref_pos) |-> $past(cmp_hi, 2) && $past(sw_sig, 2));

    // R4
    ref_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ref_neg) |-> !$past(cmp_hi, 2) && $past(sw_sig, 2));

    // R6
    bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok(rd_bcd));

    // R7
    ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ovr |-> rd_bcd == MAX_BCD);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |-> $stable(rd_bcd) && $stable(rd_pos) && $stable(rd_ovr));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R9
    done_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> $past(sw_ref_pos || sw_ref_neg));

endmodule

bind dslope_seq dslope_seq_chk #(
    .AZ_CYCLES  (AZ_CYCLES),
    .INT_CYCLES (INT_CYCLES),
    .MAX_COUNT  (MAX_COUNT),
    .DIGITS     (DIGITS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_hi     (cmp_hi),
    .sw_zero    (sw_zero),
    .sw_sig     (sw_sig),
    .sw_ref_pos (sw_ref_pos),
    .sw_ref_neg (sw_ref_neg),
    .rd_bcd     (rd_bcd),
    .rd_pos     (rd_pos),
    .rd_ovr     (rd_ovr),
    .rd_done    (rd_done)
);

// File: tb/dslope_seq_tb_top.sv
// Bench: behavioural integrator drives the comparator; each conversion's
// reading, polarity, overrange, phase lengths and ordering are compared
// with values computed here from the requirements.
module dslope_seq_tb_top;

    localparam int AZN  = 1000;
    localparam int INTN = 1000;
    localparam int FULL = 1999;
    localparam int REFSTEP = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_hi;
    logic        sw_zero, sw_sig, sw_ref_pos, sw_ref_neg;
    logic [15:0] rd_bcd;
    logic        rd_pos, rd_ovr, rd_done;

    int n_chk = 0;
    int n_bad = 0;
    int vin_r = 0;
    int integ = 0;
    int wd_cyc = 0;
    logic [3:0] sw_prev = 4'b0;

    always #5 clk = ~clk;

    dslope_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_hi     (cmp_hi),
        .sw_zero    (sw_zero),
        .sw_sig     (sw_sig),
        .sw_ref_pos (sw_ref_pos),
        .sw_ref_neg (sw_ref_neg),
        .rd_bcd     (rd_bcd),
        .rd_pos     (rd_pos),
        .rd_ovr     (rd_ovr),
        .rd_done    (rd_done)
    );

    // Integrator model: applies the switches of the previous clock.
    always @(negedge clk) begin
        if (!rst_n) begin
            integ   = 0;
            sw_prev = 4'b0;
        end else begin
            if (sw_prev[3]) integ = 0;
            if (sw_prev[2]) integ = integ + vin_r;
            if (sw_prev[1]) integ = integ - REFSTEP;
            if (sw_prev[0]) integ = integ + REFSTEP;
            sw_prev = {sw_zero, sw_sig, sw_ref_pos, sw_ref_neg};
        end
    end

    assign cmp_hi = sw_ref_neg ? (integ >= 0) : (integ > 0);

    function automatic logic [15:0] to_dec(input int v);
        logic [15:0] r;
        r[3:0]   = 4'(v % 10);
        r[7:4]   = 4'((v / 10) % 10);
        r[11:8]  = 4'((v / 100) % 10);
        r[15:12] = 4'(v / 1000);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Global watchdog.
    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd_cyc, 190000);
            finish_run();
        end
    end

    // One full conversion starting at the first zeroing clock.
    task automatic run_conv(input int vin);
        int az = 0, sg = 0, rp = 0, rn = 0, cyc = 0, stage = 0, kind;
        int m, exp_rd, exp_ref;
        bit gap_ok = 1, order_ok = 1, hold_ok = 1, exp_ovr, exp_pos;
        logic [3:0]  prv = 4'b0, cur;
        logic [15:0] held_bcd = rd_bcd;
        logic        held_pos = rd_pos, held_ovr = rd_ovr;
        vin_r   = vin;
        m       = (vin < 0) ? -vin : vin;
        exp_ovr = (m > FULL);
        exp_rd  = exp_ovr ? FULL : m;
        exp_pos = (vin > 0);
        exp_ref = exp_ovr ? FULL + 1 : m + 1;
        forever begin
            cur = {sw_zero, sw_sig, sw_ref_pos, sw_ref_neg};
            if (rd_done) break;
            if (cur[3]) az++;
            if (cur[2]) sg++;
            if (cur[1]) rp++;
            if (cur[0]) rn++;
            if (cur != 4'b0 && prv != 4'b0 && cur != prv) gap_ok = 0;
            if (cur != 4'b0) begin
                kind = cur[3] ? 0 : (cur[2] ? 1 : 2);
                if (kind == stage + 1) stage = kind;
                else if (kind != stage) order_ok = 0;
            end
            if (rd_bcd !== held_bcd || rd_pos !== held_pos || rd_ovr !== held_ovr) hold_ok = 0;
            prv = cur;
            if (cyc > 5000) begin
                check(0, "R5 conversion timeout", cyc, exp_ref);
                return;
            end
            @(negedge clk);
            cyc++;
        end
        check(rd_bcd == to_dec(exp_rd), "R5 reading", int'(rd_bcd), int'(to_dec(exp_rd)));
        check(rd_pos == exp_pos, "R4 polarity", int'(rd_pos), int'(exp_pos));
        check(rd_ovr == exp_ovr, "R7 overrange", int'(rd_ovr), int'(exp_ovr));
        check(az == AZN, "R3 zeroing length", az, AZN);
        check(sg == INTN, "R3 integrate length", sg, INTN);
        check(exp_pos ? (rp == exp_ref && rn == 0) : (rn == exp_ref && rp == 0),
              "R4 reference polarity clocks", exp_pos ? rp : rn, exp_ref);
        check(gap_ok && order_ok, "R1 phase order and break clocks", int'(order_ok), 1);
        check(hold_ok, "R8 display hold", 0, 1);
        check(cur == 4'b0, "R2 switches off at result", int'(cur), 0);
        @(negedge clk);
        check(!rd_done, "R9 done width", int'(rd_done), 0);
        check(rd_bcd == to_dec(exp_rd), "R6 reading kept", int'(rd_bcd), int'(to_dec(exp_rd)));
        check(sw_zero && !sw_sig && !sw_ref_pos && !sw_ref_neg, "R1 back to zeroing",
              int'({sw_zero, sw_sig, sw_ref_pos, sw_ref_neg}), 8);
    endtask

    task automatic check_reset_state(input string tag);
        check(sw_zero && !sw_sig && !sw_ref_pos && !sw_ref_neg, {"R10 switches ", tag},
              int'({sw_zero, sw_sig, sw_ref_pos, sw_ref_neg}), 8);
        check(rd_bcd == 16'h0 && !rd_pos && !rd_ovr && !rd_done, {"R10 outputs ", tag},
              int'(rd_bcd), 0);
    endtask

    initial begin
        int dir[10] = '{0, 1, 1999, 2000, -1, -1999, -2000, 500, 2600, -7};
        void'($urandom(32'd51719));
        repeat (4) @(negedge clk);
        check_reset_state("initial");
        rst_n = 1'b1;
        foreach (dir[i]) run_conv(dir[i]);
        for (int k = 0; k < 10; k++) begin
            run_conv(int'($urandom_range(4200)) - 2100);
        end
        // R10: reset in the middle of an integration.
        vin_r = 700;
        repeat (1500) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        run_conv(-350);
        finish_run();
    end

endmodule